// File: doc/BRIEF.md
# Compact Instruction Word Decoder

This block turns one fetched 16-bit instruction word into a decoded bundle: the format class, the operation number, two register indices, a 32-bit immediate, the instruction length in bytes and an illegal flag. The two top bits of the word choose one of three layouts: a register/register layout with an 8-bit operation, a short register/immediate layout, and a conditional-branch layout with a 10-bit signed halfword offset.

A fetch unit strobes the word in with `op_valid_i`. Most words complete on their own. Some register/register operations (load-immediate, absolute and offset loads and stores, absolute jump and call, software interrupt) carry a trailing 32-bit word. For these, the decoder holds the word until `ext_valid_i` brings the extension. The extension may also arrive in the same cycle as the opcode. The result is registered and flagged for one cycle by `dec_valid_o`, and it holds until the next instruction completes.

Top module: `insn_decoder`

## Requirements
- R1: `form_o` is 1 when opcode bit 15 is 0. It is 2 when bits [15:14] are 2'b10, and 3 when they are 2'b11. It is never 0 while `dec_valid_o` is high.
- R2: In form 1, `oper_o` = opcode[15:8], `reg_a_o` = opcode[7:4] and `reg_b_o` = opcode[3:0]. A form 1 instruction with no extension reports `imm_o` = 0.
- R3: In form 2, `oper_o` = opcode[13:12] zero-extended and `reg_a_o` = opcode[11:8]. `reg_b_o` = 0 and `imm_o` = opcode[7:0] zero-extended. All four operations (0 add, 1 subtract, 2 special-register read, 3 special-register write) are legal.
- R4: In form 3, `oper_o` = opcode[13:10] (the condition) and `reg_a_o` = `reg_b_o` = 0. `imm_o` is opcode[9:0] sign-extended to 32 bits and then shifted left by one. Offset field 0x1FF gives 1022, 0x200 gives -1024 and 0 gives 0.
- R5: Form 3 conditions 0 to 9 are legal. Conditions 10 to 15 set `illegal_o`.
- R6: The following form 1 operations are long: 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38 and 0x39. A long operation reports `len_o` = 6 and `imm_o` = the extension word. Every other instruction reports `len_o` = 2.
- R7: The legal form 1 operations are 0x00 to 0x0E and 0x19 to 0x39. Any other form 1 operation sets `illegal_o`. An illegal instruction reports `len_o` = 2 and never waits for an extension.
- R8: A strobe of a short or illegal word raises `dec_valid_o` on the next clock edge. A long word keeps `dec_valid_o` low until `ext_valid_i` is seen, and the result appears one edge after that. When `ext_valid_i` comes together with the opcode strobe, the long word completes on the next edge.
- R9: While a long word waits for its extension, `op_valid_i` is ignored. The result that follows carries the fields of the waiting word.
- R10: After reset, `dec_valid_o` is 0, every output field is 0 and no word is pending.
- R11: `dec_valid_o` is high for exactly one cycle per instruction. All output fields hold their values until the next instruction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode strobe |
| opcode_i | input | 16 | Fetched instruction word |
| ext_valid_i | input | 1 | Extension word strobe |
| ext_word_i | input | 32 | Trailing 32-bit extension word |
| dec_valid_o | output | 1 | One-cycle result flag |
| form_o | output | 2 | Format class 1, 2 or 3 |
| oper_o | output | 8 | Operation or condition number |
| reg_a_o | output | 4 | First register index |
| reg_b_o | output | 4 | Second register index |
| imm_o | output | 32 | Immediate, offset or extension word |
| len_o | output | 3 | Instruction length in bytes |
| illegal_o | output | 1 | Undefined encoding |

## Verification
A short or illegal word is due one clock edge after its strobe. A long word is due one edge after its extension strobe, and `dec_valid_o` must still be low one edge after the opcode strobe. The bench drives inputs on falling edges and samples on the next falling edge, so each result is read exactly one rising edge after the stimulus that produces it. The wait, ignore and hold cases insert extra falling-edge samples while no completion is due.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int OPC_W      = 16;
  localparam int IMM_W      = 32;
  localparam int REG_W      = 4;
  localparam int OPER_W     = 8;
  localparam int LEN_W      = 3;
  localparam int F2_IMM_W   = 8;
  localparam int F3_OFF_W   = 10;
  localparam int COND_W     = 4;
  localparam int COND_N     = 1 << COND_W;
  localparam int F3_COND_OK = 10;
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(6);

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_RR   = 2'd1,
    FORM_RI   = 2'd2,
    FORM_BR   = 2'd3
  } form_e;

  typedef struct packed {
    form_e             form;
    logic [OPER_W-1:0] oper;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
    logic              illegal;
  } dec_t;
endpackage

// File: rtl/insn_f1_table.sv
module insn_f1_table
  import insn_dec_pkg::*;
(
  input  logic [OPER_W-1:0] oper_i,
  output logic              legal_o,
  output logic              long_o
);
  localparam logic [OPER_W-1:0] LO_END   = OPER_W'(8'h0e);
  localparam logic [OPER_W-1:0] HI_START = OPER_W'(8'h19);
  localparam logic [OPER_W-1:0] HI_END   = OPER_W'(8'h39);

  always_comb begin
    legal_o = (oper_i <= LO_END) || ((oper_i >= HI_START) && (oper_i <= HI_END));
    case (oper_i)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d,
      8'h1a, 8'h1b, 8'h1d, 8'h1f, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: long_o = 1'b1;
      default:                                   long_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             f1_legal_i,
  input  logic             f1_long_i,
  output dec_t             dec_o,
  output logic             need_ext_o
);
  localparam int SEXT_W = IMM_W - F3_OFF_W - 1;

  logic [COND_N-1:0]   cond_ok;
  logic [F3_OFF_W-1:0] off;
  logic [COND_W-1:0]   cond;

  for (genvar c = 0; c < COND_N; c++) begin : g_cond
    if (c < F3_COND_OK) begin : g_ok
      assign cond_ok[c] = 1'b1;
    end else begin : g_bad
      assign cond_ok[c] = 1'b0;
    end
  end

  assign off  = opcode_i[F3_OFF_W-1:0];
  assign cond = opcode_i[13:10];

  always_comb begin
    dec_o      = '0;
    need_ext_o = 1'b0;
    dec_o.len  = LEN_SHORT;
    if (!opcode_i[15]) begin
      dec_o.form    = FORM_RR;
      dec_o.oper    = opcode_i[15:8];
      dec_o.ra      = opcode_i[7:4];
      dec_o.rb      = opcode_i[3:0];
      dec_o.illegal = !f1_legal_i;
      need_ext_o    = f1_legal_i && f1_long_i;
      if (need_ext_o) dec_o.len = LEN_LONG;
    end else if (!opcode_i[14]) begin
      dec_o.form = FORM_RI;
      dec_o.oper = OPER_W'(opcode_i[13:12]);
      dec_o.ra   = opcode_i[11:8];
      dec_o.imm  = IMM_W'(opcode_i[F2_IMM_W-1:0]);
    end else begin
      dec_o.form    = FORM_BR;
      dec_o.oper    = OPER_W'(cond);
      dec_o.imm     = {{SEXT_W{off[F3_OFF_W-1]}}, off, 1'b0};
      dec_o.illegal = !cond_ok[cond];
    end
  end
endmodule

// File: rtl/insn_ext_seq.sv
module insn_ext_seq
  import insn_dec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  dec_t             dec_i,
  input  logic             need_ext_i,
  input  logic             ext_valid_i,
  input  logic [IMM_W-1:0] ext_word_i,
  output dec_t             out_o,
  output logic             valid_o
);
  logic busy_q, busy_d;
  dec_t pend_q, pend_d;
  dec_t out_q, out_d;
  logic vld_q, vld_d;

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    out_d  = out_q;
    vld_d  = 1'b0;
    if (!busy_q) begin
      if (op_valid_i) begin
        if (need_ext_i && !ext_valid_i) begin
          busy_d = 1'b1;
          pend_d = dec_i;
        end else begin
          out_d = dec_i;
          if (need_ext_i) out_d.imm = ext_word_i;
          vld_d = 1'b1;
        end
      end
    end else if (ext_valid_i) begin
      out_d     = pend_q;
      out_d.imm = ext_word_i;
      busy_d    = 1'b0;
      vld_d     = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
    end
  end

  assign out_o   = out_q;
  assign valid_o = vld_q;

  p_wait_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ext_valid_i) |=> !vld_q);
  p_ext_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ext_valid_i) |=> (vld_q && out_q.imm == $past(ext_word_i)));
  p_short_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && op_valid_i && !need_ext_i) |=> vld_q);
  p_wait_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (busy_q ? (pend_q == $past(pend_q)) : 1'b1));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> $stable(out_q));
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              ext_valid_i,
  input  logic [IMM_W-1:0]  ext_word_i,
  output logic              dec_valid_o,
  output logic [1:0]        form_o,
  output logic [OPER_W-1:0] oper_o,
  output logic [REG_W-1:0]  reg_a_o,
  output logic [REG_W-1:0]  reg_b_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              illegal_o
);
  logic f1_legal, f1_long, need_ext;
  dec_t dec_c, dec_r;

  insn_f1_table u_tab (
    .oper_i  (opcode_i[15:8]),
    .legal_o (f1_legal),
    .long_o  (f1_long)
  );

  insn_field_split u_split (
    .opcode_i   (opcode_i),
    .f1_legal_i (f1_legal),
    .f1_long_i  (f1_long),
    .dec_o      (dec_c),
    .need_ext_o (need_ext)
  );

  insn_ext_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .dec_i       (dec_c),
    .need_ext_i  (need_ext),
    .ext_valid_i (ext_valid_i),
    .ext_word_i  (ext_word_i),
    .out_o       (dec_r),
    .valid_o     (dec_valid_o)
  );

  assign form_o    = dec_r.form;
  assign oper_o    = dec_r.oper;
  assign reg_a_o   = dec_r.ra;
  assign reg_b_o   = dec_r.rb;
  assign imm_o     = dec_r.imm;
  assign len_o     = dec_r.len;
  assign illegal_o = dec_r.illegal;

  p_form_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (form_o != 2'd0));
  p_f2_imm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && form_o == 2'd2) |-> (imm_o[IMM_W-1:F2_IMM_W] == '0 && reg_b_o == '0));
  p_f3_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && form_o == 2'd3) |-> (imm_o[0] == 1'b0));
  p_illegal_short_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && illegal_o) |-> (len_o == LEN_SHORT));
  p_len_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (len_o == LEN_SHORT || len_o == LEN_LONG));
endmodule

// File: tb/sim_insn_decoder.sv
`timescale 1ns/1ps
module sim_insn_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic        ext_valid = 1'b0;
  logic [31:0] ext_word = '0;
  logic        dv;
  logic [1:0]  form;
  logic [7:0]  oper;
  logic [3:0]  ra, rb;
  logic [31:0] imm;
  logic [2:0]  len;
  logic        ill;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  insn_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .opcode_i(opcode),
    .ext_valid_i(ext_valid), .ext_word_i(ext_word), .dec_valid_o(dv),
    .form_o(form), .oper_o(oper), .reg_a_o(ra), .reg_b_o(rb), .imm_o(imm),
    .len_o(len), .illegal_o(ill)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit f1_long(input logic [7:0] o);
    case (o)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d, 8'h1a, 8'h1b, 8'h1d,
      8'h1f, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit f1_legal(input logic [7:0] o);
    return (o <= 8'h0e) || (o >= 8'h19 && o <= 8'h39);
  endfunction

  // Strobe one word, supply its extension if due, check the bundle.
  task automatic run_word(input logic [15:0] op, input logic [31:0] ext, input bit same);
    logic [1:0]  e_form;
    logic [7:0]  e_oper;
    logic [3:0]  e_ra, e_rb;
    logic [31:0] e_imm;
    logic [2:0]  e_len;
    logic        e_ill, e_need;
    e_ra = 0; e_rb = 0; e_imm = 0; e_ill = 0; e_need = 0;
    if (!op[15]) begin
      e_form = 2'd1; e_oper = op[15:8]; e_ra = op[7:4]; e_rb = op[3:0];
      e_ill = !f1_legal(op[15:8]);
      e_need = !e_ill && f1_long(op[15:8]);
      if (e_need) e_imm = ext;
    end else if (!op[14]) begin
      e_form = 2'd2; e_oper = {6'd0, op[13:12]}; e_ra = op[11:8]; e_imm = {24'd0, op[7:0]};
    end else begin
      e_form = 2'd3; e_oper = {4'd0, op[13:10]};
      e_imm = 32'($signed(op[9:0])) * 2;
      e_ill = (op[13:10] > 4'd9);
    end
    e_len = e_need ? 3'd6 : 3'd2;
    @(negedge clk);
    opcode = op; op_valid = 1'b1; ext_valid = same; ext_word = ext;
    @(negedge clk);
    op_valid = 1'b0; ext_valid = 1'b0;
    if (e_need && !same) begin
      chk("R8", "valid low while waiting", {31'd0, dv}, 32'd0);
      ext_valid = 1'b1; ext_word = ext;
      @(negedge clk);
      ext_valid = 1'b0;
    end
    chk("R8", "valid", {31'd0, dv}, 32'd1);
    chk("R1", "form", {30'd0, form}, {30'd0, e_form});
    chk(e_form == 2'd3 ? "R4" : (e_form == 2'd2 ? "R3" : "R2"), "oper", {24'd0, oper}, {24'd0, e_oper});
    chk("R2", "reg_a", {28'd0, ra}, {28'd0, e_ra});
    chk("R2", "reg_b", {28'd0, rb}, {28'd0, e_rb});
    chk(e_form == 2'd3 ? "R4" : "R6", "imm", imm, e_imm);
    chk("R6", "len", {29'd0, len}, {29'd0, e_len});
    chk(e_form == 2'd3 ? "R5" : "R7", "illegal", {31'd0, ill}, {31'd0, e_ill});
  endtask

  task automatic t_reset();
    chk("R10", "valid after reset", {31'd0, dv}, 32'd0);
    chk("R10", "form after reset", {30'd0, form}, 32'd0);
    chk("R10", "imm after reset", imm, 32'd0);
    chk("R10", "len after reset", {29'd0, len}, 32'd0);
  endtask

  task automatic t_form1_all();
    for (int o = 0; o < 128; o++)
      run_word({o[7:0], 4'(o + 3), 4'(o * 5)}, 32'hC0DE_0000 | 32'(o * 257), 1'b0);
  endtask

  task automatic t_form2_all();
    for (int k = 0; k < 4; k++)
      run_word({2'b10, k[1:0], 4'(k + 9), 8'(8'hF0 + k)}, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_form3();
    for (int c = 0; c < 16; c++) begin
      run_word({2'b11, c[3:0], 10'h1FF}, 32'h0, 1'b0);
      run_word({2'b11, c[3:0], 10'h200}, 32'h0, 1'b0);
      run_word({2'b11, c[3:0], 10'h000}, 32'h0, 1'b0);
    end
  endtask

  task automatic t_same_cycle();
    run_word(16'h3047, 32'h1234_5678, 1'b1);  // R8 extension with opcode
    run_word(16'h0112, 32'h8765_4321, 1'b1);
  endtask

  task automatic t_wait_ignore();
    @(negedge clk);
    opcode = 16'h09A4; op_valid = 1'b1;
    @(negedge clk);
    opcode = 16'h0512;  // R9 stray strobe while waiting
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9", "valid low during ignored strobe", {31'd0, dv}, 32'd0);
    ext_valid = 1'b1; ext_word = 32'hFACE_0042;
    @(negedge clk);
    ext_valid = 1'b0;
    chk("R9", "valid", {31'd0, dv}, 32'd1);
    chk("R9", "oper of waiting word", {24'd0, oper}, 32'h09);
    chk("R9", "reg_a of waiting word", {28'd0, ra}, 32'hA);
    chk("R9", "reg_b of waiting word", {28'd0, rb}, 32'h4);
    chk("R9", "imm of waiting word", imm, 32'hFACE_0042);
    @(negedge clk);
    chk("R9", "no second result", {31'd0, dv}, 32'd0);
  endtask

  task automatic t_hold();
    run_word(16'hB7C3, 32'h0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11", "valid single cycle", {31'd0, dv}, 32'd0);
      chk("R11", "imm held", imm, 32'h0000_00C3);
      chk("R11", "reg_a held", {28'd0, ra}, 32'h7);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_form1_all();
    t_form2_all();
    t_form3();
    t_same_cycle();
    t_wait_ignore();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule